// File: doc/BRIEF.md
# Rectangle Copy Blitter

This block copies a rectangle of pixels from one place in a byte-addressed frame memory to another. Software sets up source and destination coordinates, the rectangle size, a pixel format code, per-operation or shared base offsets and pitches, and two direction flags. It then pulses a start input. The block checks the setup, walks the rectangle row by row through a single-port memory port, and pulses done. If the setup is invalid, it raises an error flag and touches no memory.

When a direction flag is reversed, the programmed coordinate is the far corner on that axis. The rectangle's near edge is then derived from it. Rows go top-down or bottom-up as requested. Within each row, bytes are moved in whichever order keeps overlapping source and destination correct. When the operation completes, the destination coordinate outputs are updated so that software can chain further copies.

The memory port issues one byte read and then one byte write. Read data returns one cycle after a read request, so each byte takes two cycles.

Top module: `rect_blit`

## Requirements
- R1: Pixel size comes from `fmt_i`: code 2 is 1 byte, codes 3 and 4 are 2 bytes, code 5 is 3 bytes and code 6 is 4 bytes. Any other code rejects the operation: `err_o`=1 with done, and no memory write.
- R2: When `x_fwd_i`=0, the programmed x is the rightmost pixel and the left edge is x+1-width, using CW-bit arithmetic. When `y_fwd_i`=0, y is treated the same way using height. This applies to both source and destination.
- R3: The byte address of pixel (x,y) is offset + y*pitch + x*bytes_per_pixel, where x and y are the left/top edges plus the pixel's position in the rectangle.
- R4: When `own_geom_i`=1, the source uses `src_off_i`/`src_pitch_i` and the destination uses `dst_off_i`/`dst_pitch_i`. When it is 0, both use `def_off_i`/`def_pitch_i`, and the per-operation values have no effect.
- R5: A selected source or destination pitch of zero rejects the operation with no writes.
- R6: A source or destination left or top edge above 0x3FFF rejects the operation. So does a rectangle whose last byte address is at or beyond MEM_BYTES. A last byte exactly at MEM_BYTES-1 is accepted.
- R7: With `y_fwd_i`=1, destination row k takes source row k, starting at k=0. With `y_fwd_i`=0, the last row is copied first and the walk moves upward.
- R8: Each row is copied correctly when it overlaps its source row. Bytes go in descending order when the destination row start is above the source row start, and in ascending order otherwise.
- R9: On success, `dst_x_o` becomes left+width if `x_fwd_i`=1 and the left edge otherwise, and `dst_y_o` becomes top+height if `y_fwd_i`=1 and the top edge otherwise. Both change only in the cycle after done. A rejected operation leaves them unchanged.
- R10: Start is taken only when `busy_o`=0, and a start while busy has no effect. Busy is high from the cycle after start until done. Done is a one-cycle pulse. `err_o` holds until the next accepted start.
- R11: A width or height of zero completes with done, no error and no memory write, and still updates the coordinates per R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request |
| src_x_i | input | CW | Source x (near or far corner) |
| src_y_i | input | CW | Source y (near or far corner) |
| dst_x_i | input | CW | Destination x (near or far corner) |
| dst_y_i | input | CW | Destination y (near or far corner) |
| width_i | input | CW | Width in pixels |
| height_i | input | CW | Height in rows |
| fmt_i | input | 4 | Pixel format code |
| x_fwd_i | input | 1 | 1: left-to-right, 0: right-to-left |
| y_fwd_i | input | 1 | 1: top-to-bottom, 0: bottom-to-top |
| own_geom_i | input | 1 | Selects per-operation offsets and pitches |
| src_off_i | input | OW | Source base offset |
| src_pitch_i | input | CW | Source pitch in bytes |
| dst_off_i | input | OW | Destination base offset |
| dst_pitch_i | input | CW | Destination pitch in bytes |
| def_off_i | input | OW | Shared default offset |
| def_pitch_i | input | CW | Shared default pitch |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last operation was rejected |
| dst_x_o | output | CW | Written-back destination x |
| dst_y_o | output | CW | Written-back destination y |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1: write, 0: read |
| mem_addr_o | output | AW | Byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, one cycle after a read request |

## Verification
The bench builds the block with MEM_BYTES=1024, with CW and OW left at their defaults. The small memory puts the end-of-memory bound within reach of short rectangles: a rectangle whose last byte lands on address 1023 is accepted, and one byte more is rejected. The 16-bit coordinates let the bench program x values of 0x4000 and produce the wrap-around left edge that a reversed x direction can create. Every one of the 1024 bytes is compared against a bench model after each operation, so any stray write anywhere in memory is caught.

// File: rtl/rect_blit_pkg.sv
package rect_blit_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_ROW,
    ST_RD,
    ST_WR,
    ST_FIN
  } blit_state_e;

  // bytes per pixel, 0 = unsupported format
  function automatic logic [2:0] fmt_bytes(input logic [3:0] code);
    case (code)
      4'd2:       return 3'd1;
      4'd3, 4'd4: return 3'd2;
      4'd5:       return 3'd3;
      4'd6:       return 3'd4;
      default:    return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/rb_pix_size.sv
module rb_pix_size
  import rect_blit_pkg::*;
(
  input  logic [3:0] fmt_i,
  output logic [2:0] bytes_o,
  output logic       valid_o
);
  assign bytes_o = fmt_bytes(fmt_i);
  assign valid_o = (bytes_o != 3'd0);
endmodule

// File: rtl/rb_edge.sv
module rb_edge #(
  parameter int CW        = 16,
  parameter int COORD_MAX = 16'h3FFF
) (
  input  logic [CW-1:0] pos_i,
  input  logic [CW-1:0] len_i,
  input  logic          fwd_i,
  output logic [CW-1:0] edge_o,
  output logic          ok_o
);
  // reversed axis: programmed position is the far pixel
  assign edge_o = fwd_i ? pos_i : CW'(pos_i + CW'(1) - len_i);
  assign ok_o   = (edge_o <= CW'(COORD_MAX));
endmodule

// File: rtl/rect_blit.sv
module rect_blit
  import rect_blit_pkg::*;
#(
  parameter int MEM_BYTES = 4096,
  parameter int CW        = 16,
  parameter int OW        = 24,
  parameter int COORD_MAX = 16'h3FFF,
  localparam int AW       = $clog2(MEM_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] src_x_i,
  input  logic [CW-1:0] src_y_i,
  input  logic [CW-1:0] dst_x_i,
  input  logic [CW-1:0] dst_y_i,
  input  logic [CW-1:0] width_i,
  input  logic [CW-1:0] height_i,
  input  logic [3:0]    fmt_i,
  input  logic          x_fwd_i,
  input  logic          y_fwd_i,
  input  logic          own_geom_i,
  input  logic [OW-1:0] src_off_i,
  input  logic [CW-1:0] src_pitch_i,
  input  logic [OW-1:0] dst_off_i,
  input  logic [CW-1:0] dst_pitch_i,
  input  logic [OW-1:0] def_off_i,
  input  logic [CW-1:0] def_pitch_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [CW-1:0] dst_x_o,
  output logic [CW-1:0] dst_y_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i
);
  localparam int XW = OW + 2 * CW + 4;
  localparam int NAX = 4;  // src x, src y, dst x, dst y

  blit_state_e state_q;

  logic [CW-1:0] sx_q, sy_q, dx_q, dy_q, w_q, h_q, sp_q, dp_q;
  logic [OW-1:0] so_q, do_q;
  logic [3:0]    fmt_q;
  logic          xf_q, yf_q, err_q;
  logic [CW-1:0] row_q;
  logic [XW-1:0] cnt_q;
  logic [AW-1:0] sptr_q, dptr_q;
  logic          desc_q;

  // pixel size
  logic [2:0] bpp;
  logic       bpp_ok;
  rb_pix_size u_pix (.fmt_i(fmt_q), .bytes_o(bpp), .valid_o(bpp_ok));

  // edge conversion per axis
  logic [CW-1:0] ax_pos [NAX];
  logic [CW-1:0] ax_len [NAX];
  logic          ax_fwd [NAX];
  logic [CW-1:0] ax_edge[NAX];
  logic          ax_ok  [NAX];

  assign ax_pos = '{sx_q, sy_q, dx_q, dy_q};
  assign ax_len = '{w_q, h_q, w_q, h_q};
  assign ax_fwd = '{xf_q, yf_q, xf_q, yf_q};

  for (genvar a = 0; a < NAX; a++) begin : g_edge
    rb_edge #(.CW(CW), .COORD_MAX(COORD_MAX)) u_edge (
      .pos_i (ax_pos[a]),
      .len_i (ax_len[a]),
      .fwd_i (ax_fwd[a]),
      .edge_o(ax_edge[a]),
      .ok_o  (ax_ok[a])
    );
  end

  // address arithmetic
  logic [XW-1:0] x_bpp, x_w, x_h, row_n;
  logic [XW-1:0] s_left, s_top, d_left, d_top;
  logic [XW-1:0] s_end, d_end, s_ri, d_ri, s_row, d_row;
  logic          zero_sz, bounds_ok, reject, row_desc;

  always_comb begin
    x_bpp  = XW'(bpp);
    x_w    = XW'(w_q);
    x_h    = XW'(h_q);
    s_left = XW'(ax_edge[0]);
    s_top  = XW'(ax_edge[1]);
    d_left = XW'(ax_edge[2]);
    d_top  = XW'(ax_edge[3]);
    row_n  = x_w * x_bpp;
    s_end  = XW'(so_q) + (s_top + x_h - 1) * XW'(sp_q) + (s_left + x_w) * x_bpp - 1;
    d_end  = XW'(do_q) + (d_top + x_h - 1) * XW'(dp_q) + (d_left + x_w) * x_bpp - 1;
    zero_sz   = (w_q == '0) || (h_q == '0);
    bounds_ok = (s_end < XW'(MEM_BYTES)) && (d_end < XW'(MEM_BYTES));
    reject    = !bpp_ok || (sp_q == '0) || (dp_q == '0) ||
                !(ax_ok[0] && ax_ok[1] && ax_ok[2] && ax_ok[3]) ||
                (!zero_sz && !bounds_ok);
    s_ri  = yf_q ? s_top + XW'(row_q) : s_top + x_h - 1 - XW'(row_q);
    d_ri  = yf_q ? d_top + XW'(row_q) : d_top + x_h - 1 - XW'(row_q);
    s_row = XW'(so_q) + s_ri * XW'(sp_q) + s_left * x_bpp;
    d_row = XW'(do_q) + d_ri * XW'(dp_q) + d_left * x_bpp;
    row_desc = (d_row > s_row);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      {sx_q, sy_q, dx_q, dy_q, w_q, h_q, sp_q, dp_q} <= '0;
      so_q <= '0; do_q <= '0; fmt_q <= '0;
      xf_q <= 1'b0; yf_q <= 1'b0; err_q <= 1'b0;
      row_q <= '0; cnt_q <= '0; sptr_q <= '0; dptr_q <= '0; desc_q <= 1'b0;
      dst_x_o <= '0; dst_y_o <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          sx_q <= src_x_i; sy_q <= src_y_i; dx_q <= dst_x_i; dy_q <= dst_y_i;
          w_q <= width_i; h_q <= height_i; fmt_q <= fmt_i;
          xf_q <= x_fwd_i; yf_q <= y_fwd_i;
          so_q <= own_geom_i ? src_off_i   : def_off_i;
          sp_q <= own_geom_i ? src_pitch_i : def_pitch_i;
          do_q <= own_geom_i ? dst_off_i   : def_off_i;
          dp_q <= own_geom_i ? dst_pitch_i : def_pitch_i;
          err_q   <= 1'b0;
          state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          row_q <= '0;
          if (reject) begin
            err_q   <= 1'b1;
            state_q <= ST_FIN;
          end else begin
            state_q <= zero_sz ? ST_FIN : ST_ROW;
          end
        end
        ST_ROW: begin
          desc_q  <= row_desc;
          sptr_q  <= AW'(row_desc ? s_row + row_n - 1 : s_row);
          dptr_q  <= AW'(row_desc ? d_row + row_n - 1 : d_row);
          cnt_q   <= row_n;
          state_q <= ST_RD;
        end
        ST_RD: state_q <= ST_WR;
        ST_WR: begin
          cnt_q  <= cnt_q - 1;
          sptr_q <= desc_q ? sptr_q - 1'b1 : sptr_q + 1'b1;
          dptr_q <= desc_q ? dptr_q - 1'b1 : dptr_q + 1'b1;
          if (cnt_q == XW'(1)) begin
            if (row_q == h_q - 1'b1) state_q <= ST_FIN;
            else begin
              row_q   <= row_q + 1'b1;
              state_q <= ST_ROW;
            end
          end else begin
            state_q <= ST_RD;
          end
        end
        ST_FIN: begin
          if (!err_q) begin
            dst_x_o <= xf_q ? CW'(ax_edge[2] + w_q) : ax_edge[2];
            dst_y_o <= yf_q ? CW'(ax_edge[3] + h_q) : ax_edge[3];
          end
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_FIN);
  assign err_o       = err_q;
  assign mem_req_o   = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we_o    = (state_q == ST_WR);
  assign mem_addr_o  = (state_q == ST_WR) ? dptr_q : sptr_q;
  assign mem_wdata_o = mem_rdata_i;

endmodule

// File: rtl/rect_blit_chk.sv
module rect_blit_chk #(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [CW-1:0] dst_x_o,
  input logic [CW-1:0] dst_y_o
);
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R10
  AST_DONE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);  // R10
  AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);  // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);  // R10
  AST_REJECT_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !err_o);  // R5
  AST_ERR_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o);  // R1
  AST_WB_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({dst_x_o, dst_y_o}) |-> $past(done_o));  // R9
endmodule

bind rect_blit rect_blit_chk #(.CW(CW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .err_o    (err_o),
  .mem_req_o(mem_req_o),
  .mem_we_o (mem_we_o),
  .dst_x_o  (dst_x_o),
  .dst_y_o  (dst_y_o)
);

// File: tb/rect_blit_test.sv
`timescale 1ns/1ps
module rect_blit_test;
  localparam int MB = 1024;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start = 1'b0;
  logic [15:0] sx, sy, dx, dy, w, h, sp, dp, dep;
  logic [23:0] so, doff, deo;
  logic [3:0]  fmt;
  logic        xf, yf, own;
  logic        busy, done, err;
  logic [15:0] dxo, dyo;
  logic        mreq, mwe;
  logic [AW-1:0] maddr;
  logic [7:0]  mwd, mrd;

  logic [7:0] mem [MB];
  logic [7:0] sh  [MB];
  int checks = 0, fails = 0;
  int ex = 0, ey = 0;

  rect_blit #(.MEM_BYTES(MB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .src_x_i(sx), .src_y_i(sy), .dst_x_i(dx), .dst_y_i(dy),
    .width_i(w), .height_i(h), .fmt_i(fmt), .x_fwd_i(xf), .y_fwd_i(yf),
    .own_geom_i(own), .src_off_i(so), .src_pitch_i(sp),
    .dst_off_i(doff), .dst_pitch_i(dp), .def_off_i(deo), .def_pitch_i(dep),
    .busy_o(busy), .done_o(done), .err_o(err), .dst_x_o(dxo), .dst_y_o(dyo),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr),
    .mem_wdata_o(mwd), .mem_rdata_i(mrd)
  );

  always @(posedge clk) begin
    if (mreq && !mwe) mrd <= mem[maddr];
    if (mreq && mwe) mem[maddr] <= mwd;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int i = 0; i < MB; i++) begin
      mem[i] = 8'((i * 7 + 3) ^ (i >> 5));
      sh[i]  = mem[i];
    end
  endtask

  task automatic setup(input int f, input int a, input int b, input int c, input int d,
                       input int ww, input int hh, input bit xx, input bit yy);
    fmt = 4'(f); sx = 16'(a); sy = 16'(b); dx = 16'(c); dy = 16'(d);
    w = 16'(ww); h = 16'(hh); xf = xx; yf = yy;
    own = 1'b1; so = 0; doff = 0; sp = 32; dp = 32; deo = 0; dep = 32;
  endtask

  // reference copy from the requirements
  task automatic model(input bit ok);
    int b, so_e, sp_e, do_e, dp_e;
    logic [15:0] sl, st, dl, dtp;
    logic [7:0] tmp [64];
    if (!ok) return;
    case (fmt) 4'd2: b = 1; 4'd3, 4'd4: b = 2; 4'd5: b = 3; default: b = 4; endcase
    so_e = own ? int'(so) : int'(deo); sp_e = own ? int'(sp) : int'(dep);
    do_e = own ? int'(doff) : int'(deo); dp_e = own ? int'(dp) : int'(dep);
    sl = xf ? sx : 16'(sx + 1 - w); st = yf ? sy : 16'(sy + 1 - h);
    dl = xf ? dx : 16'(dx + 1 - w); dtp = yf ? dy : 16'(dy + 1 - h);
    for (int k = 0; k < int'(h); k++) begin
      int rs, rd, sa, da;
      rs = yf ? int'(st) + k : int'(st) + int'(h) - 1 - k;
      rd = yf ? int'(dtp) + k : int'(dtp) + int'(h) - 1 - k;
      sa = so_e + rs * sp_e + int'(sl) * b;
      da = do_e + rd * dp_e + int'(dl) * b;
      for (int j = 0; j < int'(w) * b; j++) tmp[j] = sh[sa + j];
      for (int j = 0; j < int'(w) * b; j++) sh[da + j] = tmp[j];
    end
    ex = xf ? int'(16'(dl + w)) : int'(dl);
    ey = yf ? int'(16'(dtp + h)) : int'(dtp);
  endtask

  task automatic launch();
    int n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic verify(input string req, input bit exp_err);
    int bad = 0;
    for (int i = 0; i < MB; i++) if (mem[i] !== sh[i]) bad++;
    chk(req, "memory bytes differing", bad, 0);
    chk(req, "err_o", err, exp_err);
    chk(req, "dst_x_o", dxo, ex);
    chk(req, "dst_y_o", dyo, ey);
    chk("R10", "done one cycle", done, 0);
    chk("R10", "busy after done", busy, 0);
  endtask

  task automatic run(input string req, input bit ok);
    model(ok);
    launch();
    verify(req, !ok);
  endtask

  task automatic t_basic();   // R3 R7 R9
    init_mem(); setup(2, 1, 1, 10, 4, 5, 3, 1, 1); run("R3", 1);
  endtask
  task automatic t_far32();   // R2 R1
    init_mem(); setup(6, 4, 0, 7, 10, 3, 2, 0, 1); sp = 64; dp = 64; run("R2", 1);
  endtask
  task automatic t_btt();     // R7 bottom-up vertical overlap
    init_mem(); setup(3, 2, 5, 2, 6, 4, 4, 1, 0); run("R7", 1);
  endtask
  task automatic t_ovl_right(); // R8 descending
    init_mem(); setup(2, 0, 0, 1, 0, 8, 1, 1, 1); run("R8", 1);
  endtask
  task automatic t_ovl_left();  // R8 ascending, 24bpp
    init_mem(); setup(5, 2, 3, 1, 3, 4, 2, 1, 1); run("R8", 1);
  endtask
  task automatic t_default();   // R4
    init_mem(); setup(4, 0, 0, 3, 2, 2, 2, 1, 1);
    own = 1'b0; deo = 100; dep = 16; so = 999; sp = 0; doff = 5; dp = 0;
    run("R4", 1);
  endtask
  task automatic t_bad_fmt();   // R1
    init_mem(); setup(7, 0, 0, 4, 4, 2, 2, 1, 1); run("R1", 0);
    init_mem(); setup(0, 0, 0, 4, 4, 2, 2, 1, 1); run("R1", 0);
  endtask
  task automatic t_zero_pitch(); // R5
    init_mem(); setup(2, 0, 0, 4, 4, 2, 2, 1, 1); dp = 0; run("R5", 0);
    init_mem(); setup(2, 0, 0, 4, 4, 2, 2, 1, 1); sp = 0; run("R5", 0);
  endtask
  task automatic t_coord();     // R6
    init_mem(); setup(2, 0, 0, 16'h4000, 0, 1, 1, 1, 1); run("R6", 0);
    init_mem(); setup(2, 5, 5, 1, 0, 3, 1, 0, 1); run("R6", 0);
  endtask
  task automatic t_mem_end();   // R6
    init_mem(); setup(2, 0, 0, 28, 31, 4, 1, 1, 1); run("R6", 1);
    init_mem(); setup(2, 0, 0, 28, 31, 5, 1, 1, 1); run("R6", 0);
  endtask
  task automatic t_zero_size(); // R11
    init_mem(); setup(2, 0, 0, 5, 6, 0, 2, 1, 1); run("R11", 1);
  endtask
  task automatic t_busy_start(); // R10
    init_mem(); setup(2, 0, 0, 8, 8, 4, 2, 1, 1);
    model(1);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R10", "busy after start", busy, 1);
    repeat (3) @(negedge clk);
    dx = 20; dy = 20; start = 1'b1;
    @(negedge clk); start = 1'b0;
    begin
      int n = 0;
      while (!done && n < 5000) begin @(negedge clk); n++; end
    end
    @(negedge clk);
    verify("R10", 0);
  endtask

  initial begin
    setup(2, 0, 0, 0, 0, 1, 1, 1, 1);
    init_mem();
    repeat (3) @(negedge clk);
    chk("R10", "reset busy", busy, 0);
    chk("R10", "reset done", done, 0);
    chk("R10", "reset err", err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_far32();
    t_btt();
    t_ovl_right();
    t_ovl_left();
    t_default();
    t_bad_fmt();
    t_zero_pitch();
    t_coord();
    t_mem_end();
    t_zero_size();
    t_busy_start();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule